// File: doc/BRIEF.md
# Timer Compare Unit with Special Event

This block watches a free-running timer and compares it, every clock, with a programmable compare value. A 4-bit mode input selects the reaction to a match. The reaction can be to toggle an output pin, to drive the pin high, to drive it low, to raise only an interrupt flag, or to fire a special event. The special event returns a one-cycle pulse that tells the external timer to restart. It can also return a one-cycle pulse that starts an analog-to-digital conversion. The timer and the converter sit outside the block. They reach it only through the timer value input and the two pulse outputs.

A compare mode is entered whenever the mode input takes a new value. On entry the pin is preloaded to a level set by the mode. Any other match action in that mode only happens on a later match. The flag stays set until software pulses the clear strobe, and it is also cleared when the unit is switched off. Each instance has two parameters. One says whether the instance has the special event at all. The other says whether the special event also starts a conversion.

The control state machine has three states:
- `ST_IDLE`: the unit is off, or the mode is not a compare mode. The pin is released and no match acts.
- `ST_LOAD`: the one-cycle entry state. The pin has just been preloaded, and matches are ignored.
- `ST_ARMED`: the unit acts on matches.

The transitions are these:
- A change to any compare mode goes to `ST_LOAD`, from any state.
- A change to any other code goes to `ST_IDLE`.
- `ST_LOAD` moves to `ST_ARMED` on the next clock.
- `ST_IDLE` and `ST_ARMED` hold while the mode is unchanged.

Top module: `cmp_event_unit`

## Requirements
- R1: After reset, pin_out, pin_oe, irq_flag, tmr_clear and adc_go are all 0.
- R2: In mode 4'b0010 the pin is driven (pin_oe=1) and preloaded to 0 on entry. Each match inverts pin_out. The flag is not touched.
- R3: In mode 4'b1000 the pin is driven and preloaded to 0 on entry. A match drives pin_out to 1 and sets irq_flag.
- R4: In mode 4'b1001 the pin is driven and preloaded to 1 on entry. A match drives pin_out to 0 and sets irq_flag.
- R5: In mode 4'b1010 pin_oe is 0 and pin_out is 0. A match only sets irq_flag.
- R6: In mode 4'b1011, on an instance with the special event, a match sets irq_flag and pulses tmr_clear high for exactly one cycle. When ADC_TRIG_EN=1 it also pulses adc_go high in that same cycle.
- R7: On an instance built with HAS_EVENT=0, mode 4'b1011 behaves exactly as mode 4'b1010: it sets the flag only, and tmr_clear and adc_go stay 0.
- R8: Mode 4'b0000 clears irq_flag and releases the pin (pin_oe=0). While it is held, matches have no effect.
- R9: A match is counted only on the first sampled cycle where tmr_val equals cmp_val. A timer that holds at the compare value does not act again.
- R10: A flag_clr pulse clears irq_flag on the next clock. If a flag-setting match is sampled in the same cycle, the flag ends up set.
- R11: The mode-entry preload appears on the clock that first samples the new mode. A match sampled on the next clock (the load cycle) is ignored. Matches act from the following clock on, with outputs updating on the clock edge that samples the match.
- R12: Codes other than 0000, 0010 and 1000-1011 (for example 0100 or 1100) keep the unit idle: pin_oe=0, no flag and no pulses, and the flag is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 4 | Compare mode select |
| cmp_val | input | W | Compare value |
| tmr_val | input | W | Current value of the external timer |
| flag_clr | input | 1 | Strobe that clears the interrupt flag |
| pin_out | output | 1 | Compare output pin level |
| pin_oe | output | 1 | Output enable for the pin |
| irq_flag | output | 1 | Sticky match flag |
| tmr_clear | output | 1 | One-cycle pulse that restarts the external timer |
| adc_go | output | 1 | One-cycle pulse that starts a conversion |

## Verification
The timer is driven across the compare value in several ways. It steps onto the value from below and from above, so the bench can tell a real match from a level. It also holds on the value for two cycles, which separates edge detection from level detection. In one case it sits on the value in the load cycle, which shows whether the arming delay works. Every compare mode is visited in turn after another mode, so the preload level on entry can be told apart from the previous pin state. The clear strobe is applied both alone and together with a match, which pins down which of the two wins. A second instance without the special event gets the same stimulus, which shows how the event mode falls back.

// File: rtl/cmp_event_pkg.sv
package cmp_event_pkg;

    localparam logic [3:0] MD_OFF    = 4'b0000;
    localparam logic [3:0] MD_TOGGLE = 4'b0010;
    localparam logic [3:0] MD_SET    = 4'b1000;
    localparam logic [3:0] MD_CLR    = 4'b1001;
    localparam logic [3:0] MD_FLAG   = 4'b1010;
    localparam logic [3:0] MD_EVENT  = 4'b1011;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_OFF,
        ACT_TOGGLE,
        ACT_SET,
        ACT_CLEAR,
        ACT_FLAG,
        ACT_EVENT
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ARMED
    } state_e;

    function automatic logic act_is_compare(input act_e a);
        return (a == ACT_TOGGLE) || (a == ACT_SET) || (a == ACT_CLEAR) ||
               (a == ACT_FLAG)   || (a == ACT_EVENT);
    endfunction

    function automatic logic act_drives_pin(input act_e a);
        return (a == ACT_TOGGLE) || (a == ACT_SET) || (a == ACT_CLEAR);
    endfunction

endpackage

// File: rtl/cmp_mode_decode.sv
module cmp_mode_decode
    import cmp_event_pkg::*;
#(
    parameter bit HAS_EVENT = 1'b1
) (
    input  logic [3:0] mode,
    output act_e       act
);

    act_e ev_act;

    generate
        if (HAS_EVENT) begin : g_event
            assign ev_act = ACT_EVENT;
        end else begin : g_no_event
            assign ev_act = ACT_FLAG;
        end
    endgenerate

    always_comb begin
        act = ACT_IDLE;
        case (mode)
            MD_OFF:    act = ACT_OFF;
            MD_TOGGLE: act = ACT_TOGGLE;
            MD_SET:    act = ACT_SET;
            MD_CLR:    act = ACT_CLEAR;
            MD_FLAG:   act = ACT_FLAG;
            MD_EVENT:  act = ev_act;
            default:   act = ACT_IDLE;
        endcase
    end

endmodule

// File: rtl/cmp_match_detect.sv
module cmp_match_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tmr_val,
    input  logic [W-1:0] cmp_val,
    output logic         hit
);

    logic eq_now;
    logic eq_prev;

    assign eq_now = (tmr_val == cmp_val);
    assign hit    = eq_now && !eq_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_prev <= 1'b0;
        end else begin
            eq_prev <= eq_now;
        end
    end

endmodule

// File: rtl/cmp_ctrl_fsm.sv
module cmp_ctrl_fsm
    import cmp_event_pkg::*;
#(
    parameter bit ADC_TRIG_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode,
    input  act_e       act,
    input  logic       hit,
    input  logic       flag_clr,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       irq_flag,
    output logic       tmr_clear,
    output logic       adc_go
);

    state_e     state;
    state_e     state_nx;
    logic [3:0] mode_q;
    act_e       act_q;
    logic       changed;
    logic       fire;

    assign changed = (mode != mode_q);
    assign fire    = (state == ST_ARMED) && hit && !changed;

    always_comb begin
        state_nx = state;
        if (changed) begin
            state_nx = act_is_compare(act) ? ST_LOAD : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_LOAD:  state_nx = ST_ARMED;
                ST_ARMED: state_nx = ST_ARMED;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // State register, with the mode it was entered for
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= MD_OFF;
            act_q  <= ACT_OFF;
        end else begin
            state  <= state_nx;
            mode_q <= mode;
            act_q  <= act;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_out   <= 1'b0;
            irq_flag  <= 1'b0;
            tmr_clear <= 1'b0;
            adc_go    <= 1'b0;
        end else begin
            tmr_clear <= 1'b0;
            adc_go    <= 1'b0;
            if (changed) begin
                pin_out <= (act == ACT_CLEAR);
                if (act == ACT_OFF || flag_clr) begin
                    irq_flag <= 1'b0;
                end
            end else begin
                if (flag_clr) begin
                    irq_flag <= 1'b0;
                end
                if (fire) begin
                    case (act)
                        ACT_TOGGLE: pin_out <= !pin_out;
                        ACT_SET: begin
                            pin_out  <= 1'b1;
                            irq_flag <= 1'b1;
                        end
                        ACT_CLEAR: begin
                            pin_out  <= 1'b0;
                            irq_flag <= 1'b1;
                        end
                        ACT_FLAG: irq_flag <= 1'b1;
                        ACT_EVENT: begin
                            irq_flag  <= 1'b1;
                            tmr_clear <= 1'b1;
                            adc_go    <= ADC_TRIG_EN;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign pin_oe = (state != ST_IDLE) && act_drives_pin(act_q);

endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
    import cmp_event_pkg::*;
#(
    parameter int W           = 16,
    parameter bit HAS_EVENT   = 1'b1,
    parameter bit ADC_TRIG_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   mode,
    input  logic [W-1:0] cmp_val,
    input  logic [W-1:0] tmr_val,
    input  logic         flag_clr,
    output logic         pin_out,
    output logic         pin_oe,
    output logic         irq_flag,
    output logic         tmr_clear,
    output logic         adc_go
);

    act_e act;
    logic hit;

    cmp_mode_decode #(.HAS_EVENT(HAS_EVENT)) u_decode (
        .mode (mode),
        .act  (act)
    );

    cmp_match_detect #(.W(W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .tmr_val (tmr_val),
        .cmp_val (cmp_val),
        .hit     (hit)
    );

    cmp_ctrl_fsm #(.ADC_TRIG_EN(ADC_TRIG_EN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .act       (act),
        .hit       (hit),
        .flag_clr  (flag_clr),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_flag  (irq_flag),
        .tmr_clear (tmr_clear),
        .adc_go    (adc_go)
    );

endmodule

// File: rtl/cmp_event_checker.sv
module cmp_event_checker
    import cmp_event_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   mode,
    input logic [W-1:0] cmp_val,
    input logic [W-1:0] tmr_val,
    input logic         pin_out,
    input logic         pin_oe,
    input logic         irq_flag,
    input logic         tmr_clear,
    input logic         adc_go
);

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clear |=> !tmr_clear);

    assert_adc_with_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_go |-> tmr_clear);

    assert_clear_needs_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && tmr_clear) |-> $past(tmr_val == cmp_val));

    assert_flag_needs_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && $rose(irq_flag)) |-> $past(tmr_val == cmp_val));

    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && $past(mode) == MD_OFF && mode == MD_OFF)
            |-> (!irq_flag && !pin_oe && !tmr_clear));

    assert_flag_mode_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && $past(mode) == MD_FLAG && mode == MD_FLAG) |-> !pin_oe);

    assert_set_rise_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && $past(mode, 2) == MD_SET && $past(mode) == MD_SET && $rose(pin_out))
            |-> irq_flag);

endmodule

bind cmp_event_unit cmp_event_checker #(.W(W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .cmp_val   (cmp_val),
    .tmr_val   (tmr_val),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_flag  (irq_flag),
    .tmr_clear (tmr_clear),
    .adc_go    (adc_go)
);

// File: tb/cmp_event_unit_test.sv
module cmp_event_unit_test;

    typedef struct packed {
        logic pin;
        logic oe;
        logic flg;
        logic trs;
        logic adc;
        logic flg2;
        logic trs2;
        logic adc2;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [15:0] cmp_val = 16'd100;
    logic [15:0] tmr_val = 16'd0;
    logic        flag_clr = 1'b0;

    logic pin_out, pin_oe, irq_flag, tmr_clear, adc_go;
    logic n_pin, n_oe, n_flag, n_clear, n_adc;

    int   tests = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t expq[$];
    string tagq[$];

    always #10 clk = ~clk;

    cmp_event_unit #(.W(16), .HAS_EVENT(1'b1), .ADC_TRIG_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cmp_val(cmp_val),
        .tmr_val(tmr_val), .flag_clr(flag_clr), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_flag(irq_flag), .tmr_clear(tmr_clear),
        .adc_go(adc_go)
    );

    cmp_event_unit #(.W(16), .HAS_EVENT(1'b0), .ADC_TRIG_EN(1'b1)) uut_noev (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cmp_val(cmp_val),
        .tmr_val(tmr_val), .flag_clr(flag_clr), .pin_out(n_pin),
        .pin_oe(n_oe), .irq_flag(n_flag), .tmr_clear(n_clear),
        .adc_go(n_adc)
    );

    function automatic exp_t mk(input logic p, input logic o, input logic f,
                                input logic t, input logic a, input logic f2,
                                input logic t2, input logic a2);
        exp_t e;
        e.pin = p; e.oe = o; e.flg = f; e.trs = t; e.adc = a;
        e.flg2 = f2; e.trs2 = t2; e.adc2 = a2;
        return e;
    endfunction

    // Driver: apply one cycle of stimulus and queue what must follow the next edge
    task automatic step(input logic [3:0] m, input logic [15:0] t, input logic c,
                        input exp_t e, input string tag);
        @(negedge clk);
        mode = m;
        tmr_val = t;
        flag_clr = c;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    // Monitor: compare a quarter period after each rising edge
    always begin
        @(posedge clk);
        #5;
        if (expq.size() > 0) begin
            exp_t  e;
            exp_t  g;
            string tg;
            e  = expq.pop_front();
            tg = tagq.pop_front();
            g  = mk(pin_out, pin_oe, irq_flag, tmr_clear, adc_go, n_flag, n_clear, n_adc);
            tests++;
            if (g !== e) begin
                fails++;
                $display("FAIL %s: got pin,oe,flag,clr,adc|flag2,clr2,adc2=%b expected %b",
                         tg, g, e);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step(4'd0,  16'd0,   1'b0, mk(0,0,0,0,0, 0,0,0), "R1");
        // R2 toggle mode, R11 entry and ignored load-cycle match
        step(4'd2,  16'd0,   1'b0, mk(0,1,0,0,0, 0,0,0), "R11");
        step(4'd2,  16'd100, 1'b0, mk(0,1,0,0,0, 0,0,0), "R11");
        step(4'd2,  16'd5,   1'b0, mk(0,1,0,0,0, 0,0,0), "R2");
        step(4'd2,  16'd100, 1'b0, mk(1,1,0,0,0, 0,0,0), "R2");
        step(4'd2,  16'd100, 1'b0, mk(1,1,0,0,0, 0,0,0), "R9");
        step(4'd2,  16'd101, 1'b0, mk(1,1,0,0,0, 0,0,0), "R2");
        step(4'd2,  16'd100, 1'b0, mk(0,1,0,0,0, 0,0,0), "R2");
        // R3 set-on-match
        step(4'd8,  16'd0,   1'b0, mk(0,1,0,0,0, 0,0,0), "R3");
        step(4'd8,  16'd0,   1'b0, mk(0,1,0,0,0, 0,0,0), "R3");
        step(4'd8,  16'd100, 1'b0, mk(1,1,1,0,0, 1,0,0), "R3");
        step(4'd8,  16'd101, 1'b1, mk(1,1,0,0,0, 0,0,0), "R10");
        // R4 clear-on-match
        step(4'd9,  16'd0,   1'b0, mk(1,1,0,0,0, 0,0,0), "R4");
        step(4'd9,  16'd0,   1'b0, mk(1,1,0,0,0, 0,0,0), "R4");
        step(4'd9,  16'd100, 1'b0, mk(0,1,1,0,0, 1,0,0), "R4");
        step(4'd9,  16'd100, 1'b1, mk(0,1,0,0,0, 0,0,0), "R9");
        step(4'd9,  16'd0,   1'b0, mk(0,1,0,0,0, 0,0,0), "R4");
        step(4'd9,  16'd100, 1'b1, mk(0,1,1,0,0, 1,0,0), "R10");
        // R5 flag only
        step(4'd10, 16'd0,   1'b0, mk(0,0,1,0,0, 1,0,0), "R5");
        step(4'd10, 16'd0,   1'b1, mk(0,0,0,0,0, 0,0,0), "R10");
        step(4'd10, 16'd100, 1'b0, mk(0,0,1,0,0, 1,0,0), "R5");
        // R6 special event, R7 fallback on the instance without it
        step(4'd11, 16'd0,   1'b1, mk(0,0,0,0,0, 0,0,0), "R6");
        step(4'd11, 16'd0,   1'b0, mk(0,0,0,0,0, 0,0,0), "R6");
        step(4'd11, 16'd100, 1'b0, mk(0,0,1,1,1, 1,0,0), "R6");
        step(4'd11, 16'd100, 1'b0, mk(0,0,1,0,0, 1,0,0), "R6");
        step(4'd11, 16'd0,   1'b1, mk(0,0,0,0,0, 0,0,0), "R10");
        step(4'd11, 16'd100, 1'b0, mk(0,0,1,1,1, 1,0,0), "R7");
        // R8 off
        step(4'd0,  16'd0,   1'b0, mk(0,0,0,0,0, 0,0,0), "R8");
        step(4'd0,  16'd100, 1'b0, mk(0,0,0,0,0, 0,0,0), "R8");
        // R12 other codes idle
        step(4'd4,  16'd0,   1'b0, mk(0,0,0,0,0, 0,0,0), "R12");
        step(4'd4,  16'd100, 1'b0, mk(0,0,0,0,0, 0,0,0), "R12");
        step(4'd12, 16'd0,   1'b0, mk(0,0,0,0,0, 0,0,0), "R12");
        step(4'd12, 16'd100, 1'b0, mk(0,0,0,0,0, 0,0,0), "R12");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule